// File: doc/BRIEF.md
# Dithered Half-Step PWM Generator

This block drives a pulse-width modulated output from a step counter whose period is a fixed number of ticks (50 by default). The counter moves only on cycles where the clock enable `step_en` is high, so one step equals one enable tick. With a 1 MHz tick rate, a 50-step period gives a 20 kHz output rate.

The duty command has twice the resolution of the counter. It runs from 0 to 100 and gives roughly 1% control. An even command 2n gives a coarse duty of n high ticks in every period. An odd command 2n+1 switches between n and n+1 high ticks on successive periods, so the average is n + 0.5. This doubles the resolution without a longer counter. The command is a plain level input. It is sampled only at the period boundary, so it can be changed at any time without tearing a period. A one-cycle `period_start` strobe marks each new period.

Top module: `pwmd_dither_pwm`

## Requirements
- R1: One period is exactly 50 enabled ticks. The counter runs 0 to 49 and then wraps to 0.
- R2: `pwm_out` is high while the counter value is below the coarse duty of the current period, so the number of high ticks in a period equals that coarse duty.
- R3: An even command 2n gives a coarse duty of n in every period.
- R4: An odd command 2n+1 gives n in odd-numbered periods and n+1 in even-numbered periods. The periods are counted 1, 2, 3, ... from the first wrap after reset. The dither phase toggles at every wrap, whatever the command is.
- R5: The command is latched only on the tick where the counter wraps. A change of command in the middle of a period has no effect on that period. A value that is held only between wraps never reaches the output.
- R6: A command of 0 keeps the output low for the whole period. A command of 100 keeps it high for all 50 ticks. Any command above 100 is treated as 100.
- R7: `period_start` is high for exactly one clock cycle, the cycle after the wrap tick, while the counter reads 0.
- R8: Reset (`rst_n` low) clears the counter, the latched duty and the dither phase. The outputs are then low, and the period that runs from reset to the first wrap has a duty of 0.
- R9: On a cycle where `step_en` is low, the counter, `pwm_out` and the strobe do not advance. No new strobe appears on such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Step tick enable; one high cycle advances the counter by one |
| duty_cmd | input | 7 | Fine duty command, 0 to 100; larger values are clamped |
| pwm_out | output | 1 | Modulated output |
| period_start | output | 1 | One-cycle strobe at the start of each period |

## Verification
The scoreboard expects a count of high ticks for every completed period. These counts are compared against commands at the ends of the range (0, 100, 101, 127), against even values, and against odd values (1, 49, 73, 99). The even values show that the level holds steady. The odd values show which of the two adjacent coarse duties each period gets, which exposes a reversed or missing phase toggle. A command that is changed in the middle of a period and replaced before the wrap shows whether the command is sampled at the wrong time. Runs with a sparse, pseudo-random enable show whether the counter, the output or the strobe ever advance without a tick.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/pwmd_step_counter.sv
module pwmd_step_counter #(
  parameter int STEPS = 50,
  parameter int CNT_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  assign wrap = step_en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step_en) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwmd_duty_sel.sv
module pwmd_duty_sel
  import pwmd_pkg::*;
#(
  parameter int STEPS  = 50,
  parameter int CMD_W  = 7,
  parameter int DUTY_W = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [CMD_W-1:0]  duty_cmd,
  output logic [DUTY_W-1:0] duty_q
);
  localparam int               CMD_MAX   = 2 * STEPS;
  localparam logic [CMD_W-1:0] CMD_LIMIT = CMD_W'(CMD_MAX);

  phase_e             phase_q;
  logic [CMD_W-1:0]   cmd_clamped;
  logic [DUTY_W-1:0]  half_duty;
  logic               add_half;
  logic [DUTY_W-1:0]  duty_next;

  always_comb begin
    cmd_clamped = (duty_cmd > CMD_LIMIT) ? CMD_LIMIT : duty_cmd;
    half_duty   = DUTY_W'(cmd_clamped >> 1);
    add_half    = cmd_clamped[0] && (phase_q == PH_HIGH);
    duty_next   = half_duty + DUTY_W'(add_half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q  <= '0;
      phase_q <= PH_LOW;
    end else if (wrap) begin
      duty_q  <= duty_next;
      phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end
  end
endmodule

// File: rtl/pwmd_out_stage.sv
module pwmd_out_stage #(
  parameter int CNT_W  = 6,
  parameter int DUTY_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [DUTY_W-1:0] duty_q,
  output logic              pwm_out,
  output logic              period_start
);
  localparam int CMP_W = (CNT_W > DUTY_W) ? CNT_W : DUTY_W;

  logic [CMP_W-1:0] cnt_ext;
  logic [CMP_W-1:0] duty_ext;

  assign cnt_ext  = CMP_W'(cnt_q);
  assign duty_ext = CMP_W'(duty_q);
  assign pwm_out  = cnt_ext < duty_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_start <= 1'b0;
    end else begin
      period_start <= wrap;
    end
  end
endmodule

// File: rtl/pwmd_dither_pwm.sv
module pwmd_dither_pwm #(
  parameter int STEPS = 50,
  parameter int CMD_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [CMD_W-1:0] duty_cmd,
  output logic             pwm_out,
  output logic             period_start
);
  localparam int CNT_W  = $clog2(STEPS);
  localparam int DUTY_W = $clog2(STEPS + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DUTY_W-1:0] duty_q;
  logic              wrap;

  pwmd_step_counter #(.STEPS(STEPS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .cnt_q(cnt_q), .wrap(wrap)
  );

  pwmd_duty_sel #(.STEPS(STEPS), .CMD_W(CMD_W), .DUTY_W(DUTY_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .duty_cmd(duty_cmd), .duty_q(duty_q)
  );

  pwmd_out_stage #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_out (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .cnt_q(cnt_q), .duty_q(duty_q),
    .pwm_out(pwm_out), .period_start(period_start)
  );
endmodule

// File: rtl/pwmd_checker.sv
module pwmd_checker #(
  parameter int STEPS  = 50,
  parameter int CNT_W  = 6,
  parameter int DUTY_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_en,
  input logic              pwm_out,
  input logic              period_start,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DUTY_W-1:0] duty_q
);
  // R1: the counter never leaves 0..STEPS-1
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(STEPS));

  // R7: the strobe lasts exactly one cycle
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  // R7: the strobe coincides with a counter reading 0
  a_r7_strobe_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> (cnt_q == '0));

  // R5: the latched duty changes only at a period boundary
  a_r5_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(duty_q));

  // R6: the coarse duty never exceeds the period
  a_r6_duty_bound: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q <= DUTY_W'(STEPS));

  // R6: a zero duty keeps the output low
  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !pwm_out);

  // R9: no tick, no counter movement
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cnt_q));
endmodule

bind pwmd_dither_pwm pwmd_checker #(.STEPS(STEPS), .CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .pwm_out(pwm_out),
  .period_start(period_start), .cnt_q(cnt_q), .duty_q(duty_q)
);

// File: tb/sim_pwmd_dither_pwm.sv
`timescale 1ns/1ps
module sim_pwmd_dither_pwm;
  localparam int STEPS = 50;

  typedef struct {
    int    duty;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_en = 1'b0;
  logic [6:0] duty_cmd = '0;
  logic       pwm_out;
  logic       period_start;

  int   checks = 0;
  int   fails = 0;
  int   starts = 0;
  int   hi_cnt = 0;
  int   tick_cnt = 0;
  bit   sparse = 1'b0;
  bit   prev_en = 1'b0;
  bit   prev_pwm = 1'b0;
  bit   prev_ps = 1'b0;
  bit   armed = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  pwmd_dither_pwm #(.STEPS(STEPS), .CMD_W(7)) u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .duty_cmd(duty_cmd),
    .pwm_out(pwm_out), .period_start(period_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected coarse duty of period p (p >= 1) for command c
  function automatic int model(input int c, input int p);
    int cc = (c > 2 * STEPS) ? 2 * STEPS : c;
    int n  = cc / 2;
    if ((cc % 2 == 1) && (p % 2 == 0)) n++;
    return n;
  endfunction

  // Enable driver: dense or pseudo-random sparse ticks
  always @(posedge clk) begin
    #5;
    if (!sparse) begin
      step_en = 1'b1;
    end else begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step_en = lfsr[0] | lfsr[2];
    end
  end

  // Monitor: closes a period at every strobe and compares with the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (armed && !prev_en) begin
        chk(pwm_out == prev_pwm, "R9", int'(pwm_out), int'(prev_pwm), "output moved without tick");
        chk(!period_start, "R9", int'(period_start), 0, "strobe without tick");
      end
      if (period_start) begin
        exp_t e;
        chk(!prev_ps, "R7", int'(prev_ps), 0, "strobe longer than one cycle");
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", hi_cnt, -1, "no expected period queued");
        end else begin
          e = exp_q.pop_front();
          chk(hi_cnt == e.duty, e.req, hi_cnt, e.duty, $sformatf("high ticks in period %0d", starts));
        end
        chk(tick_cnt == STEPS, "R1", tick_cnt, STEPS, "ticks per period");
        hi_cnt = 0;
        tick_cnt = 0;
        starts++;
      end
      if (step_en) begin
        tick_cnt++;
        if (pwm_out) hi_cnt++;
      end
      prev_en  = step_en;
      prev_pwm = pwm_out;
      prev_ps  = period_start;
      armed    = 1'b1;
    end
  end

  task automatic wait_starts(input int target);
    while (starts < target) begin
      @(negedge clk);
      #2;
    end
  endtask

  // Command is set during the current period; it governs the next k periods
  task automatic run(input int c, input int k, input string req);
    int base = starts;
    duty_cmd = 7'(c);
    for (int i = 1; i <= k; i++) begin
      exp_t e;
      e.duty = model(c, base + i);
      e.req  = req;
      exp_q.push_back(e);
    end
    wait_starts(base + k);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    chk(1'b0, "R1", starts, -1, "watchdog expired");
    finish_run();
  end

  initial begin
    exp_t e0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R8", int'(pwm_out), 0, "pwm in reset");
    chk(period_start == 1'b0, "R8", int'(period_start), 0, "strobe in reset");
    @(posedge clk);
    #5 rst_n = 1'b1;
    e0.duty = 0;
    e0.req  = "R8";
    exp_q.push_back(e0);

    run(0, 2, "R6");
    run(100, 2, "R6");
    run(40, 2, "R3");
    run(49, 4, "R4");
    run(1, 2, "R4");
    run(99, 2, "R4");
    run(127, 2, "R6");
    run(101, 1, "R6");
    // R5: a value held only in mid-period must never appear
    duty_cmd = 7'd90;
    repeat (20) @(negedge clk);
    run(10, 2, "R5");
    run(62, 2, "R3");
    sparse = 1'b1;
    run(73, 4, "R9");
    run(2, 2, "R3");
    finish_run();
  end
endmodule